// File: doc/BRIEF.md
# Programmable Rule-Table State Machine

This block is a finite state machine whose states and transitions are loaded at run time, not fixed in logic. A configuration port fills two tables. The state table holds a numeric value for each state slot. The rule table holds entries with a source-state index or a wildcard, a target-state index, and a condition. Each condition selects one bit of a digital input vector and may invert it.

On each cycle where the step strobe is high, the machine scans the loaded rules in a fixed priority order. It takes at most one transition. The current state index and the value stored for that state are always visible at the outputs. A one-cycle pulse marks every transition taken.

While state slot 0 has not been loaded, the machine has no states. In that case it never moves. It still reports the evaluated condition of every valid rule on a combinational output, so it can serve as plain decode logic on the inputs.

Top module: `rtab_fsm`

## Requirements
- R1: After reset, both tables are empty. The outputs then read: state index 0, state value 0, `active` 0, `chg` 0 and `cond_out` all zero.
- R2: Writing state slot `a` with value `v` (`st_we`=1) marks the slot loaded from the next cycle on. `state_val` always shows the value stored in the slot named by `state_idx`; an unloaded slot reads 0.
- R3: A rule fires on a step only when all of the following hold: its entry is valid, its condition is true, and either its wildcard flag is set or its source index equals the current state. The condition is true when `in_vec[bit]` XOR `inv` equals 1. When a rule fires, the next state is the rule's target.
- R4: All matching wildcard rules take priority over all matching non-wildcard rules. Within each of the two groups, the matching rule with the lowest table index wins.
- R5: At most one rule fires per step. A chain such as 0→1→2 therefore needs two steps.
- R6: The state holds when `step_i` is low, or when no rule matches on a step.
- R7: A cycle that writes either table (`st_we` or `rl_we` high) returns the machine to state 0 on the next edge. A step strobe in that same cycle is ignored.
- R8: `chg` is high for exactly the one cycle after the edge at which a rule fired, and is low otherwise.
- R9: While state slot 0 is unloaded, `active` is 0 and no rule fires. `cond_out[i]` always equals `r_valid[i]` AND the condition of rule `i`, combinationally from `in_vec`, whatever the state.
- R10: A rule is skipped when its entry is invalid or when its target slot is unloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_we | input | 1 | Write enable for the state table |
| st_addr | input | 3 | State slot to write |
| st_val | input | 8 | Value stored for that slot |
| rl_we | input | 1 | Write enable for the rule table |
| rl_addr | input | 4 | Rule slot to write |
| rl_valid | input | 1 | Entry is valid |
| rl_wild | input | 1 | Rule matches any current state |
| rl_old | input | 3 | Source state index |
| rl_new | input | 3 | Target state index |
| rl_bit | input | 3 | Input bit tested by the condition |
| rl_inv | input | 1 | Invert the tested bit |
| step_i | input | 1 | Step strobe |
| in_vec | input | 8 | Condition input vector |
| state_idx | output | 3 | Current state index |
| state_val | output | 8 | Value of the current state |
| active | output | 1 | State slot 0 is loaded |
| chg | output | 1 | Transition pulse |
| cond_out | output | 16 | Per-rule evaluated condition |

## Verification
The bench sets up cases where a wildcard rule with a high index and an ordinary rule with a low index are both true. A design that scanned in plain index order would move to the ordinary rule's target instead of the wildcard's. It also offers a two-link chain in one step: a design that chained transitions would skip the middle state. It holds a step high during a table write: a design that honoured the step would leave state 0 and raise `chg`. It points a rule at an unloaded slot and runs with no states loaded: a design that ignored either case would jump to a slot that has no value. A long random phase mixes steps, inputs and writes against a behavioural model checked on every cycle.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
    parameter int unsigned RTAB_STATES = 8;
    parameter int unsigned RTAB_RULES  = 16;
    parameter int unsigned RTAB_IN_W   = 8;
    parameter int unsigned RTAB_VAL_W  = 8;

    // which priority group produced the winning rule
    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_WILD  = 2'd1,
        GRP_PLAIN = 2'd2
    } rtab_grp_e;
endpackage

// File: rtl/rtab_tables.sv
module rtab_tables #(
    parameter int unsigned NS = rtab_pkg::RTAB_STATES,
    parameter int unsigned NR = rtab_pkg::RTAB_RULES,
    parameter int unsigned IW = rtab_pkg::RTAB_IN_W,
    parameter int unsigned VW = rtab_pkg::RTAB_VAL_W,
    localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int unsigned RW = (NR > 1) ? $clog2(NR) : 1,
    localparam int unsigned BW = (IW > 1) ? $clog2(IW) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_we,
    input  logic [SW-1:0]          st_addr,
    input  logic [VW-1:0]          st_val,
    input  logic                   rl_we,
    input  logic [RW-1:0]          rl_addr,
    input  logic                   rl_valid,
    input  logic                   rl_wild,
    input  logic [SW-1:0]          rl_old,
    input  logic [SW-1:0]          rl_new,
    input  logic [BW-1:0]          rl_bit,
    input  logic                   rl_inv,
    output logic [NS-1:0]          s_loaded,
    output logic [NS-1:0][VW-1:0]  s_val,
    output logic [NR-1:0]          r_valid,
    output logic [NR-1:0]          r_wild,
    output logic [NR-1:0][SW-1:0]  r_old,
    output logic [NR-1:0][SW-1:0]  r_new,
    output logic [NR-1:0][BW-1:0]  r_bit,
    output logic [NR-1:0]          r_inv
);
    typedef struct packed {
        logic [NS-1:0]         ld;
        logic [NS-1:0][VW-1:0] val;
        logic [NR-1:0]         valid;
        logic [NR-1:0]         wild;
        logic [NR-1:0][SW-1:0] old_s;
        logic [NR-1:0][SW-1:0] new_s;
        logic [NR-1:0][BW-1:0] bsel;
        logic [NR-1:0]         inv;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (st_we && (int'(st_addr) < int'(NS))) begin
            tbl_d.ld[st_addr]  = 1'b1;
            tbl_d.val[st_addr] = st_val;
        end
        if (rl_we && (int'(rl_addr) < int'(NR))) begin
            tbl_d.valid[rl_addr] = rl_valid;
            tbl_d.wild[rl_addr]  = rl_wild;
            tbl_d.old_s[rl_addr] = rl_old;
            tbl_d.new_s[rl_addr] = rl_new;
            tbl_d.bsel[rl_addr]  = rl_bit;
            tbl_d.inv[rl_addr]   = rl_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign s_loaded = tbl_q.ld;
    assign s_val    = tbl_q.val;
    assign r_valid  = tbl_q.valid;
    assign r_wild   = tbl_q.wild;
    assign r_old    = tbl_q.old_s;
    assign r_new    = tbl_q.new_s;
    assign r_bit    = tbl_q.bsel;
    assign r_inv    = tbl_q.inv;

    // R2: a state write is visible from the following cycle
    a_r2_state_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && (int'(st_addr) < int'(NS))) |=>
            (s_loaded[$past(st_addr)] && (s_val[$past(st_addr)] == $past(st_val))));

    // R10: a rule write stores its valid flag as given
    a_r10_rule_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_we && (int'(rl_addr) < int'(NR))) |=> (r_valid[$past(rl_addr)] == $past(rl_valid)));
endmodule

// File: rtl/rtab_match.sv
module rtab_match #(
    parameter int unsigned NS = rtab_pkg::RTAB_STATES,
    parameter int unsigned NR = rtab_pkg::RTAB_RULES,
    parameter int unsigned IW = rtab_pkg::RTAB_IN_W,
    localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int unsigned BW = (IW > 1) ? $clog2(IW) : 1
) (
    input  logic [IW-1:0]          in_vec,
    input  logic [SW-1:0]          cur,
    input  logic                   active,
    input  logic [NS-1:0]          s_loaded,
    input  logic [NR-1:0]          r_valid,
    input  logic [NR-1:0]          r_wild,
    input  logic [NR-1:0][SW-1:0]  r_old,
    input  logic [NR-1:0][SW-1:0]  r_new,
    input  logic [NR-1:0][BW-1:0]  r_bit,
    input  logic [NR-1:0]          r_inv,
    output logic [NR-1:0]          cond_out,
    output logic [NR-1:0]          match
);
    for (genvar g = 0; g < NR; g++) begin : g_rule
        logic cnd;
        logic src_ok;
        logic dst_ok;
        always_comb begin
            cnd         = in_vec[r_bit[g]] ^ r_inv[g];
            src_ok      = r_wild[g] | (r_old[g] == cur);
            dst_ok      = s_loaded[r_new[g]];
            cond_out[g] = r_valid[g] & cnd;
            match[g]    = cond_out[g] & active & src_ok & dst_ok;
        end
    end
endmodule

// File: rtl/rtab_pick.sv
module rtab_pick
    import rtab_pkg::*;
#(
    parameter int unsigned NR = rtab_pkg::RTAB_RULES,
    localparam int unsigned RW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NR-1:0]  match,
    input  logic [NR-1:0]  wild,
    output logic           hit,
    output logic [RW-1:0]  idx,
    output rtab_grp_e      grp
);
    logic          w_hit, p_hit;
    logic [RW-1:0] w_idx, p_idx;

    // downward scan leaves the lowest matching index in each group
    always_comb begin
        w_hit = 1'b0;
        p_hit = 1'b0;
        w_idx = '0;
        p_idx = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (match[i] && wild[i]) begin
                w_hit = 1'b1;
                w_idx = RW'(i);
            end
            if (match[i] && !wild[i]) begin
                p_hit = 1'b1;
                p_idx = RW'(i);
            end
        end
    end

    always_comb begin
        hit = w_hit | p_hit;
        idx = w_hit ? w_idx : p_idx;
        grp = w_hit ? GRP_WILD : (p_hit ? GRP_PLAIN : GRP_NONE);
    end

    // R4: a plain winner only when no wildcard rule matches
    a_r4_wild_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == GRP_PLAIN) |-> ((match & wild) == '0));

    // R5: the winner is one of the matching rules, and none is picked without a match
    a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match[idx]);
    a_r6_no_match_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |-> (!hit && grp == GRP_NONE));
endmodule

// File: rtl/rtab_fsm.sv
module rtab_fsm #(
    parameter int unsigned NS = rtab_pkg::RTAB_STATES,
    parameter int unsigned NR = rtab_pkg::RTAB_RULES,
    parameter int unsigned IW = rtab_pkg::RTAB_IN_W,
    parameter int unsigned VW = rtab_pkg::RTAB_VAL_W,
    localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int unsigned RW = (NR > 1) ? $clog2(NR) : 1,
    localparam int unsigned BW = (IW > 1) ? $clog2(IW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_we,
    input  logic [SW-1:0]  st_addr,
    input  logic [VW-1:0]  st_val,
    input  logic           rl_we,
    input  logic [RW-1:0]  rl_addr,
    input  logic           rl_valid,
    input  logic           rl_wild,
    input  logic [SW-1:0]  rl_old,
    input  logic [SW-1:0]  rl_new,
    input  logic [BW-1:0]  rl_bit,
    input  logic           rl_inv,
    input  logic           step_i,
    input  logic [IW-1:0]  in_vec,
    output logic [SW-1:0]  state_idx,
    output logic [VW-1:0]  state_val,
    output logic           active,
    output logic           chg,
    output logic [NR-1:0]  cond_out
);
    import rtab_pkg::*;

    typedef struct packed {
        logic [SW-1:0] idx;
        logic          chg;
    } fsm_t;

    logic [NS-1:0]         s_loaded;
    logic [NS-1:0][VW-1:0] s_val;
    logic [NR-1:0]         r_valid, r_wild, r_inv;
    logic [NR-1:0][SW-1:0] r_old, r_new;
    logic [NR-1:0][BW-1:0] r_bit;
    logic [NR-1:0]         match;
    logic                  hit;
    logic [RW-1:0]         win;
    rtab_grp_e             grp;
    logic                  cfg_wr;
    fsm_t                  fsm_d, fsm_q;

    rtab_tables #(.NS(NS), .NR(NR), .IW(IW), .VW(VW)) u_tables (
        .clk(clk), .rst_n(rst_n),
        .st_we(st_we), .st_addr(st_addr), .st_val(st_val),
        .rl_we(rl_we), .rl_addr(rl_addr), .rl_valid(rl_valid), .rl_wild(rl_wild),
        .rl_old(rl_old), .rl_new(rl_new), .rl_bit(rl_bit), .rl_inv(rl_inv),
        .s_loaded(s_loaded), .s_val(s_val),
        .r_valid(r_valid), .r_wild(r_wild), .r_old(r_old), .r_new(r_new),
        .r_bit(r_bit), .r_inv(r_inv)
    );

    rtab_match #(.NS(NS), .NR(NR), .IW(IW)) u_match (
        .in_vec(in_vec), .cur(fsm_q.idx), .active(active), .s_loaded(s_loaded),
        .r_valid(r_valid), .r_wild(r_wild), .r_old(r_old), .r_new(r_new),
        .r_bit(r_bit), .r_inv(r_inv),
        .cond_out(cond_out), .match(match)
    );

    rtab_pick #(.NR(NR)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .match(match), .wild(r_wild),
        .hit(hit), .idx(win), .grp(grp)
    );

    assign cfg_wr = st_we | rl_we;
    assign active = s_loaded[0];

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.chg = 1'b0;
        if (cfg_wr) begin
            fsm_d.idx = '0;
        end else if (step_i && hit) begin
            fsm_d.idx = r_new[win];
            fsm_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign state_idx = fsm_q.idx;
    assign state_val = s_val[fsm_q.idx];
    assign chg       = fsm_q.chg;

    // R7: any table write sends the machine home and suppresses the step
    a_r7_cfg_home: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we || rl_we) |=> (state_idx == '0 && !chg));

    // R6: no strobe, no write: state unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !(st_we || rl_we)) |=> $stable(state_idx));

    // R8: a pulse only follows a strobe in a cycle without a write
    a_r8_chg_source: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> ($past(step_i) && !$past(st_we || rl_we)));

    // R9: with no states loaded the machine sits in slot 0 with no pulse
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (state_idx == '0 && !chg));

    // R10: a transition never lands on an unloaded slot
    a_r10_loaded_target: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> s_loaded[state_idx]);
endmodule

// File: tb/rtab_fsm_tb_top.sv
module rtab_fsm_tb_top;
    localparam int NS = 8;
    localparam int NR = 16;
    localparam int IW = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_we = 1'b0;
    logic [2:0]    st_addr = '0;
    logic [VW-1:0] st_val = '0;
    logic          rl_we = 1'b0;
    logic [3:0]    rl_addr = '0;
    logic          rl_valid = 1'b0, rl_wild = 1'b0, rl_inv = 1'b0;
    logic [2:0]    rl_old = '0, rl_new = '0, rl_bit = '0;
    logic          step_i = 1'b0;
    logic [IW-1:0] in_vec = '0;
    logic [2:0]    state_idx;
    logic [VW-1:0] state_val;
    logic          active, chg;
    logic [NR-1:0] cond_out;

    always #5 clk = ~clk;

    rtab_fsm dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_we(st_we), .st_addr(st_addr), .st_val(st_val),
        .rl_we(rl_we), .rl_addr(rl_addr), .rl_valid(rl_valid), .rl_wild(rl_wild),
        .rl_old(rl_old), .rl_new(rl_new), .rl_bit(rl_bit), .rl_inv(rl_inv),
        .step_i(step_i), .in_vec(in_vec),
        .state_idx(state_idx), .state_val(state_val), .active(active),
        .chg(chg), .cond_out(cond_out)
    );

    int errors = 0;
    int checks = 0;
    bit run = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_ld[NS], m_val[NS];
    int m_rv[NR], m_rw[NR], m_ro[NR], m_rn[NR], m_rb[NR], m_ri[NR];
    int m_state = 0;
    bit m_chg = 0;
    int m_next;
    bit m_fired;

    function automatic bit m_cond(int i);
        return (m_rv[i] != 0) && ((in_vec[m_rb[i]] ^ m_ri[i][0]) == 1'b1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_ld[i]) begin m_ld[i] = 0; m_val[i] = 0; end
            foreach (m_rv[i]) begin
                m_rv[i] = 0; m_rw[i] = 0; m_ro[i] = 0; m_rn[i] = 0; m_rb[i] = 0; m_ri[i] = 0;
            end
            m_state = 0;
            m_chg = 0;
        end else begin
            m_next = m_state;
            m_fired = 0;
            if (st_we || rl_we) begin
                m_next = 0;
            end else if (step_i && m_ld[0] != 0) begin
                for (int pass = 0; pass < 2; pass++) begin
                    for (int i = 0; i < NR; i++) begin
                        if (!m_fired && m_cond(i) && ((m_rw[i] != 0) == (pass == 0)) &&
                            (m_rw[i] != 0 || m_ro[i] == m_state) && m_ld[m_rn[i]] != 0) begin
                            m_fired = 1;
                            m_next = m_rn[i];
                        end
                    end
                end
            end
            m_state = m_next;
            m_chg = m_fired;
            if (st_we) begin m_ld[st_addr] = 1; m_val[st_addr] = int'(st_val); end
            if (rl_we) begin
                m_rv[rl_addr] = int'(rl_valid); m_rw[rl_addr] = int'(rl_wild);
                m_ro[rl_addr] = int'(rl_old);   m_rn[rl_addr] = int'(rl_new);
                m_rb[rl_addr] = int'(rl_bit);   m_ri[rl_addr] = int'(rl_inv);
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (run && rst_n && !done) begin
            logic [NR-1:0] exp_cond;
            for (int i = 0; i < NR; i++) exp_cond[i] = m_cond(i);
            chk(state_idx == 3'(m_state), "R3/R5/R6", "state_idx", state_idx, m_state);
            chk(state_val == VW'(m_val[m_state]), "R2", "state_val", state_val, m_val[m_state]);
            chk(chg == m_chg, "R8", "chg", chg, m_chg);
            chk(active == (m_ld[0] != 0), "R9", "active", active, m_ld[0]);
            chk(cond_out == exp_cond, "R9", "cond_out", cond_out, exp_cond);
        end
    end

    task automatic drive(input bit s, input bit sw, input bit rw);
        @(posedge clk); #1;
        step_i = s; st_we = sw; rl_we = rw;
    endtask

    task automatic idle();
        drive(0, 0, 0);
    endtask

    task automatic wr_state(input int a, input int v);
        @(posedge clk); #1;
        step_i = 0; rl_we = 0; st_we = 1; st_addr = 3'(a); st_val = VW'(v);
    endtask

    task automatic wr_rule(input int a, input bit v, input bit w, input int o,
                           input int n, input int b, input bit inv);
        @(posedge clk); #1;
        step_i = 0; st_we = 0; rl_we = 1; rl_addr = 4'(a);
        rl_valid = v; rl_wild = w; rl_old = 3'(o); rl_new = 3'(n); rl_bit = 3'(b); rl_inv = inv;
    endtask

    task automatic step(input int iv);
        @(posedge clk); #1;
        st_we = 0; rl_we = 0; step_i = 1; in_vec = IW'(iv);
    endtask

    // one step, then look at the result in the cycle after the capturing edge
    task automatic step_expect(input int iv, input int exp_idx, input bit exp_chg, input string req);
        step(iv);
        idle();
        @(negedge clk);
        chk(state_idx == 3'(exp_idx), req, "state_idx", state_idx, exp_idx);
        chk(chg == exp_chg, req, "chg", chg, exp_chg);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1;
        @(negedge clk);
        // R1: empty tables after reset
        chk(state_idx == 0 && state_val == 0, "R1", "reset state", state_idx, 0);
        chk(!active && !chg, "R1", "reset flags", {active, chg}, 0);
        chk(cond_out == '0, "R1", "reset cond_out", cond_out, 0);

        // R9: rules present, no states: conditions visible, no movement
        wr_rule(0, 1, 0, 0, 1, 0, 0);
        wr_rule(1, 1, 1, 0, 2, 1, 1);
        idle();
        in_vec = 8'h01;
        @(negedge clk);
        chk(cond_out == 16'h0003, "R9", "cond_out no states", cond_out, 3);
        step_expect(1, 0, 0, "R9");

        // R2: load states and read the value of slot 0
        wr_state(0, 10); wr_state(1, 11); wr_state(2, 12); wr_state(3, 13);
        idle();
        @(negedge clk);
        chk(state_val == 10, "R2", "state_val slot0", state_val, 10);

        // R4: wildcard at index 1 beats plain at index 0
        step_expect(1, 2, 1, "R4");
        @(negedge clk);
        chk(state_val == 12, "R2", "state_val slot2", state_val, 12);

        // R7: table write returns home
        wr_rule(1, 0, 1, 0, 2, 1, 1);
        idle();
        @(negedge clk);
        chk(state_idx == 0, "R7", "home after write", state_idx, 0);

        // R3: plain rule fires
        step_expect(1, 1, 1, "R3");
        // R8: pulse lasts one cycle
        @(negedge clk);
        chk(chg == 0, "R8", "pulse width", chg, 0);

        // R4 within group, R5 chain
        wr_rule(2, 1, 0, 0, 3, 0, 0);
        wr_rule(3, 1, 0, 1, 2, 0, 0);
        step_expect(1, 1, 1, "R4");
        step_expect(1, 2, 1, "R5");
        // R6: nothing matches from state 2
        step_expect(0, 2, 0, "R6");

        // R10: target slot unloaded is skipped
        wr_rule(4, 1, 0, 0, 5, 2, 0);
        step_expect(4, 0, 0, "R10");
        wr_state(5, 55);
        step_expect(4, 5, 1, "R10");
        @(negedge clk);
        chk(state_val == 55, "R2", "state_val slot5", state_val, 55);

        // R7: strobe during a write is ignored
        @(posedge clk); #1;
        rl_we = 0; step_i = 1; in_vec = 8'h01; st_we = 1; st_addr = 3'd6; st_val = 8'd66;
        idle();
        @(negedge clk);
        chk(state_idx == 0 && chg == 0, "R7", "step during write", state_idx, 0);

        // random mix against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 29));
            if (r == 0)
                wr_state(int'($urandom_range(0, NS - 1)), int'($urandom_range(0, 255)));
            else if (r == 1)
                wr_rule(int'($urandom_range(0, NR - 1)), 1'($urandom_range(0, 3) != 0),
                        1'($urandom_range(0, 3) == 0), int'($urandom_range(0, NS - 1)),
                        int'($urandom_range(0, NS - 1)), int'($urandom_range(0, IW - 1)),
                        1'($urandom_range(0, 1)));
            else if (r < 20)
                step(int'($urandom_range(0, 255)));
            else begin
                idle();
                in_vec = IW'($urandom_range(0, 255));
            end
        end
        idle();
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule